// File: doc/BRIEF.md
# NAND Flash Host Window Bridge

This block lets a host drive an 8-bit NAND flash device through plain memory-mapped loads and stores. The host address space is cut into four equal windows of 32 KiB each. Which window a store lands in decides the kind of flash bus cycle: a plain data cycle, a command-latch cycle (CLE high) or an address-latch cycle (ALE high). A load from the data window runs a read-enable cycle and returns the byte found on the flash data bus. The fourth window is a small register space. It holds a control register with one enable bit and one select-assert bit per chip, and a status word that reports the synchronized ready/busy pin.

Chip select is owned by software. It stays asserted for as long as the control bits say so, which lets a whole command, address and data sequence run under one select. Every flash cycle is timed by a state machine with these states: `ST_IDLE` (waiting, `req_ready` high), `ST_SETUP` (latch lines and write data settle, one clock), `ST_STROBE` (write-enable or read-enable low for `STROBE_CYC` clocks), `ST_HOLD` (strobe high, latch lines and write data held for `HOLD_CYC` clocks) and `ST_RESP` (one-clock response). The transitions are: idle-to-setup on an accepted flash access, idle-to-response on an accepted local access, setup-to-strobe after one clock, strobe-to-hold when the strobe count ends, hold-to-response when the hold count ends, and response-to-idle always. The host is stalled through `req_ready` until the response is given.

Top module: `nand_window_bridge`

## Requirements
- R1: While and right after reset, every `nand_ce_n` bit is 1, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_dq_oe` are 0, and `req_ready` is 1.
- R2: A store to the data window (address 0x00000–0x07FFF) gives exactly one `nand_we_n` low pulse of `STROBE_CYC` clocks (default 3). During the pulse `nand_cle` and `nand_ale` are 0, `nand_dq_oe` is 1 and `nand_dq_out` equals `req_wdata[7:0]`.
- R3: A store to the command window (0x08000–0x0FFFF) gives one write pulse with `nand_cle` 1 and `nand_ale` 0 across it, and carries `req_wdata[7:0]`.
- R4: A store to the address window (0x10000–0x17FFF) gives one write pulse with `nand_ale` 1 and `nand_cle` 0 across it.
- R5: `nand_cle` and `nand_ale` are never 1 in the same clock.
- R6: A load from the data window gives one `nand_re_n` low pulse of `STROBE_CYC` clocks with `nand_dq_oe` 0. `rsp_rdata` is the `nand_dq_in` value sampled in the last clock before `nand_re_n` rises, with zeros above bit 7.
- R7: The control register sits at 0x18050. For chip n, bit 2n is the enable and bit 2n+1 is the select-assert. `nand_ce_n[n]` is 0 only when both bits are 1. The register reads back as written.
- R8: `nand_ce_n` changes only after a control register store. It stays unchanged across any number of flash cycles in between.
- R9: `nand_rb` passes through a two-flop synchronizer. The status word at 0x18054 reads bit 0 = 1 when the flash is ready and bit 0 = 0 when it is busy, with zeros above.
- R10: After an accepted request, `req_ready` stays 0 until `rsp_valid` has been 1 for one clock. A flash access responds on clock `STROBE_CYC+HOLD_CYC+2` after acceptance, and a local access responds on the first clock. After a write pulse, `nand_dq_oe` and the data stay valid for `HOLD_CYC` clocks (default 2).
- R11: A load from the command or address window, or a load from an unmapped register offset, returns 0 and makes no strobe. A store to the status word or to another unmapped location changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (18) | Byte address within the bridge |
| req_wdata | input | DW (32) | Store data |
| rsp_valid | output | 1 | One-clock response strobe |
| rsp_rdata | output | DW (32) | Load data, valid with `rsp_valid` |
| nand_ce_n | output | NUM_CS (1) | Active-low chip selects |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write enable |
| nand_re_n | output | 1 | Active-low read enable |
| nand_dq_out | output | 8 | Flash data bus, driven value |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Flash data bus, received value |
| nand_rb | input | 1 | Ready/busy from flash, 1 = ready |

## Verification
The assertions assume that the host keeps `req_addr`, `req_write` and `req_wdata` steady during the clock in which `req_valid` meets `req_ready`. They also assume that `nand_dq_in` and `nand_rb` are plain two-valued levels. The bench keeps to this by changing every input only on the falling clock edge and by raising `req_valid` only while the bridge is idle. The ready/busy delay check also assumes that reset is released only while the pin is stable, and the bench does so by holding `nand_rb` at 1 through reset.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

    typedef enum logic [2:0] {
        CK_LOCAL   = 3'd0,
        CK_DATA_WR = 3'd1,
        CK_CMD_WR  = 3'd2,
        CK_ADDR_WR = 3'd3,
        CK_DATA_RD = 3'd4
    } cycle_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_STROBE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_RESP   = 3'd4
    } cyc_state_e;

endpackage

// File: rtl/nwb_rb_sync.sv
module nwb_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_pin,
    output logic rb_ready
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= rb_pin;
            stage2_q <= stage1_q;
        end
    end

    assign rb_ready = stage2_q;

    // R9: a rise seen at the output was on the pin two clocks earlier
    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_ready) |-> $past(rb_pin, 2));

endmodule

// File: rtl/nwb_ctrl_reg.sv
module nwb_ctrl_reg #(
    parameter int NUM_CS = 1,
    parameter int CTRL_W = 2 * NUM_CS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [NUM_CS-1:0] ce_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
        assign ce_n[n] = ~(ctrl_q[2*n] & ctrl_q[2*n+1]);
    end

    // R8: selects move only after a control store
    assert_ce_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ce_n));

endmodule

// File: rtl/nwb_cycle_fsm.sv
module nwb_cycle_fsm
    import nwb_pkg::*;
#(
    parameter int DW         = 32,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  cycle_kind_e kind,
    input  logic [7:0]  wbyte,
    input  logic [DW-1:0] local_rdata,
    output logic        busy,
    output logic        done,
    output logic [DW-1:0] rdata,
    output logic        we_n,
    output logic        re_n,
    output logic        cle,
    output logic        ale,
    output logic [7:0]  dq_out,
    output logic        dq_oe,
    input  logic [7:0]  dq_in
);
    localparam int MAX_CYC = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

    cyc_state_e      state_q, state_d;
    cycle_kind_e     kind_q;
    logic [CNT_W-1:0] cnt_q;
    logic [7:0]      byte_q;
    logic [DW-1:0]   rdata_q;
    logic            active;
    logic            flash_wr;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = (kind == CK_LOCAL) ? ST_RESP : ST_SETUP;
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (cnt_q == STROBE_LAST) state_d = ST_HOLD;
            ST_HOLD:   if (cnt_q == HOLD_LAST) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= CK_LOCAL;
            cnt_q   <= '0;
            byte_q  <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_d != state_q) ? '0 : cnt_q + 1'b1;
            if (state_q == ST_IDLE && start) begin
                kind_q  <= kind;
                byte_q  <= wbyte;
                rdata_q <= (kind == CK_LOCAL) ? local_rdata : '0;
            end
            if (state_q == ST_STROBE && cnt_q == STROBE_LAST && kind_q == CK_DATA_RD) begin
                rdata_q <= DW'(dq_in);
            end
        end
    end

    // outputs
    always_comb begin
        active   = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        flash_wr = (kind_q == CK_DATA_WR) || (kind_q == CK_CMD_WR) || (kind_q == CK_ADDR_WR);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_RESP);
        rdata    = rdata_q;
        cle      = active && (kind_q == CK_CMD_WR);
        ale      = active && (kind_q == CK_ADDR_WR);
        we_n     = !((state_q == ST_STROBE) && flash_wr);
        re_n     = !((state_q == ST_STROBE) && (kind_q == CK_DATA_RD));
        dq_oe    = active && flash_wr;
        dq_out   = byte_q;
    end

    assert_cle_ale_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));

    assert_we_drives_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (dq_oe && re_n));

    assert_re_bus_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!dq_oe && !cle && !ale));

    // R10: data held after the write strobe rises
    assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (dq_oe && $stable(dq_out)));

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: rtl/nand_window_bridge.sv
module nand_window_bridge
    import nwb_pkg::*;
#(
    parameter int NUM_CS     = 1,
    parameter int ADDR_W     = 18,
    parameter int DW         = 32,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_rb
);
    localparam int WIN_SH = 15;
    localparam int REG_W  = ADDR_W - WIN_SH;
    localparam int CTRL_W = 2 * NUM_CS;
    localparam logic [REG_W-1:0]  WIN_DATA = REG_W'(0);
    localparam logic [REG_W-1:0]  WIN_CMD  = REG_W'(1);
    localparam logic [REG_W-1:0]  WIN_ADDR = REG_W'(2);
    localparam logic [REG_W-1:0]  WIN_REGS = REG_W'(3);
    localparam logic [WIN_SH-1:0] OFS_CTRL = WIN_SH'('h50);
    localparam logic [WIN_SH-1:0] OFS_STAT = WIN_SH'('h54);

    logic [REG_W-1:0]  win;
    logic [WIN_SH-1:0] ofs;
    cycle_kind_e       kind;
    logic              busy;
    logic              accept;
    logic              ctrl_we;
    logic [CTRL_W-1:0] ctrl_q;
    logic              rb_ready;
    logic [DW-1:0]     local_rdata;

    assign win       = req_addr[ADDR_W-1:WIN_SH];
    assign ofs       = req_addr[WIN_SH-1:0];
    assign req_ready = !busy;
    assign accept    = req_valid && !busy;
    assign ctrl_we   = accept && req_write && (win == WIN_REGS) && (ofs == OFS_CTRL);

    always_comb begin
        unique case (win)
            WIN_DATA: kind = req_write ? CK_DATA_WR : CK_DATA_RD;
            WIN_CMD:  kind = req_write ? CK_CMD_WR  : CK_LOCAL;
            WIN_ADDR: kind = req_write ? CK_ADDR_WR : CK_LOCAL;
            default:  kind = CK_LOCAL;
        endcase
    end

    always_comb begin
        local_rdata = '0;
        if (!req_write && win == WIN_REGS) begin
            if (ofs == OFS_CTRL)      local_rdata = DW'(ctrl_q);
            else if (ofs == OFS_STAT) local_rdata = DW'(rb_ready);
        end
    end

    nwb_rb_sync u_rb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_pin   (nand_rb),
        .rb_ready (rb_ready)
    );

    nwb_ctrl_reg #(
        .NUM_CS (NUM_CS),
        .CTRL_W (CTRL_W)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_we),
        .wr_data (req_wdata[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q),
        .ce_n    (nand_ce_n)
    );

    nwb_cycle_fsm #(
        .DW         (DW),
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .kind        (kind),
        .wbyte       (req_wdata[7:0]),
        .local_rdata (local_rdata),
        .busy        (busy),
        .done        (rsp_valid),
        .rdata       (rsp_rdata),
        .we_n        (nand_we_n),
        .re_n        (nand_re_n),
        .cle         (nand_cle),
        .ale         (nand_ale),
        .dq_out      (nand_dq_out),
        .dq_oe       (nand_dq_oe),
        .dq_in       (nand_dq_in)
    );

    assert_accept_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_resp_then_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

endmodule

// File: tb/test_nand_window_bridge.sv
module test_nand_window_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CS = 1;
    localparam int ADDR_W = 18;
    localparam int DW     = 32;
    localparam int STROBE = 3;
    localparam int HOLD   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [NUM_CS-1:0] nand_ce_n;
    logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0] nand_dq_out;
    logic [7:0] nand_dq_in = 8'h00;
    logic nand_rb = 1'b1;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_window_bridge #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DW(DW),
        .STROBE_CYC(STROBE), .HOLD_CYC(HOLD)
    ) i_nand_window_bridge (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    // pin monitor, sampled on the falling edge
    int we_run = 0, we_pulses = 0, last_we_w = 0;
    int re_run = 0, re_pulses = 0, last_re_w = 0;
    int hold_run = 0, last_hold = 0;
    int both_latch = 0;
    logic last_cle = 0, last_ale = 0;
    logic [7:0] last_dq = 0;
    logic in_hold = 0;

    always @(negedge clk) begin
        if (nand_cle && nand_ale) both_latch++;
        if (!nand_we_n) begin
            we_run++;
            last_cle <= nand_cle;
            last_ale <= nand_ale;
            last_dq  <= nand_dq_out;
            in_hold  <= 1'b0;
        end else if (we_run != 0) begin
            we_pulses++;
            last_we_w = we_run;
            we_run = 0;
            in_hold <= nand_dq_oe;
            hold_run = nand_dq_oe ? 1 : 0;
            last_hold = hold_run;
        end else if (in_hold) begin
            if (nand_dq_oe && nand_dq_out == last_dq) begin
                hold_run++;
                last_hold = hold_run;
            end else begin
                in_hold <= 1'b0;
            end
        end
        if (!nand_re_n) re_run++;
        else if (re_run != 0) begin
            re_pulses++;
            last_re_w = re_run;
            re_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input bit wr, input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output int lat, output bit stalled);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        stalled = !req_ready || rsp_valid;
        lat = 1;
        while (!rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
    endtask

    task automatic t_reset();
        chk(nand_ce_n == '1, "R1 ce_n", nand_ce_n, 1);
        chk(nand_we_n && nand_re_n, "R1 strobes high", {nand_we_n, nand_re_n}, 3);
        chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches/oe low",
            {nand_cle, nand_ale, nand_dq_oe}, 0);
        chk(req_ready, "R1 req_ready", req_ready, 1);
    endtask

    task automatic t_ctrl();
        logic [DW-1:0] rd; int lat; bit st;
        bus(1, 18'h18050, 32'h1, rd, lat, st);
        @(negedge clk);
        chk(nand_ce_n[0] == 1'b1, "R7 enable only", nand_ce_n, 1);
        bus(1, 18'h18050, 32'h2, rd, lat, st);
        @(negedge clk);
        chk(nand_ce_n[0] == 1'b1, "R7 assert only", nand_ce_n, 1);
        bus(1, 18'h18050, 32'h3, rd, lat, st);
        chk(lat == 1, "R10 local latency", lat, 1);
        @(negedge clk);
        chk(nand_ce_n[0] == 1'b0, "R7 both set", nand_ce_n, 0);
        bus(0, 18'h18050, 0, rd, lat, st);
        chk(rd == 32'h3, "R7 readback", rd, 3);
    endtask

    task automatic t_write(input logic [ADDR_W-1:0] a, input logic [7:0] b,
                           input bit ecle, input bit eale, input string tag);
        logic [DW-1:0] rd; int lat; bit st; int p0;
        p0 = we_pulses;
        bus(1, a, {24'hABCDEF, b}, rd, lat, st);
        repeat (2) @(negedge clk);
        chk(we_pulses == p0 + 1, tag, we_pulses - p0, 1);
        chk(last_we_w == STROBE, tag, last_we_w, STROBE);
        chk(last_cle == ecle && last_ale == eale, tag, {last_cle, last_ale}, {ecle, eale});
        chk(last_dq == b, tag, last_dq, b);
        chk(last_hold == HOLD, "R10 write hold", last_hold, HOLD);
        chk(st, "R10 stall after accept", st, 1);
        chk(lat == STROBE + HOLD + 2, "R10 flash latency", lat, STROBE + HOLD + 2);
        chk(nand_ce_n[0] == 1'b0, "R8 select kept", nand_ce_n, 0);
    endtask

    task automatic t_read();
        logic [DW-1:0] rd; int lat; bit st; int w0;
        w0 = we_pulses;
        nand_dq_in = 8'h11;
        fork
            bus(0, 18'h00010, 0, rd, lat, st);
            begin
                @(negedge clk);
                while (nand_re_n) @(negedge clk);
                repeat (STROBE - 1) @(negedge clk);
                nand_dq_in = 8'hC3;
            end
        join
        repeat (2) @(negedge clk);
        chk(rd == 32'h000000C3, "R6 read value", rd, 32'hC3);
        chk(last_re_w == STROBE, "R6 read width", last_re_w, STROBE);
        chk(we_pulses == w0, "R6 no write pulse", we_pulses - w0, 0);
    endtask

    task automatic t_unmapped();
        logic [DW-1:0] rd; int lat; bit st; int r0, w0;
        r0 = re_pulses; w0 = we_pulses;
        nand_dq_in = 8'h5A;
        bus(0, 18'h08000, 0, rd, lat, st);
        chk(rd == 0 && lat == 1, "R11 cmd window read", rd, 0);
        bus(0, 18'h10004, 0, rd, lat, st);
        chk(rd == 0, "R11 addr window read", rd, 0);
        bus(0, 18'h18060, 0, rd, lat, st);
        chk(rd == 0, "R11 unmapped reg read", rd, 0);
        bus(1, 18'h18054, 32'h0, rd, lat, st);
        bus(1, 18'h1C050, 32'h0, rd, lat, st);
        repeat (2) @(negedge clk);
        chk(re_pulses == r0 && we_pulses == w0, "R11 no strobe",
            re_pulses + we_pulses, r0 + w0);
        chk(nand_ce_n[0] == 1'b0, "R11 select untouched", nand_ce_n, 0);
        bus(0, 18'h18050, 0, rd, lat, st);
        chk(rd == 32'h3, "R11 ctrl untouched", rd, 3);
    endtask

    task automatic t_rb();
        logic [DW-1:0] rd; int lat; bit st;
        @(negedge clk); nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        bus(0, 18'h18054, 0, rd, lat, st);
        chk(rd == 32'h0, "R9 busy", rd, 0);
        @(negedge clk); nand_rb = 1'b1;
        repeat (3) @(negedge clk);
        bus(0, 18'h18054, 0, rd, lat, st);
        chk(rd == 32'h1, "R9 ready", rd, 1);
    endtask

    task automatic t_release();
        logic [DW-1:0] rd; int lat; bit st;
        bus(1, 18'h18050, 32'h1, rd, lat, st);
        @(negedge clk);
        chk(nand_ce_n[0] == 1'b1, "R8 select released", nand_ce_n, 1);
        chk(both_latch == 0, "R5 cle and ale exclusive", both_latch, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_write(18'h00123, 8'hA5, 1'b0, 1'b0, "R2 data write");
        t_write(18'h08000, 8'h70, 1'b1, 1'b0, "R3 command write");
        t_write(18'h10000, 8'h3C, 1'b0, 1'b1, "R4 address write");
        t_read();
        t_unmapped();
        t_rb();
        t_release();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule